// File: doc/BRIEF.md
# Two's-Complement ALU with Condition Flags and Branch Test

This block does the arithmetic and logic work of a small processor datapath. It takes two operands of a width set by a parameter, a 4-bit operation code and a carry input. It returns the result at once, with no register on the way. It also raises a write-enable that tells the register file whether the result should be stored.

Each operation also produces four status bits: carry, zero, sign and overflow. These go into a flag register on the clock edge, but only when the flag-update enable is high. Compare and test set the flags and write no result, so code can test operands without losing a register. Three extra operations change only the carry flag.

A 3-bit condition selector picks one of eight branch tests. The test is applied to the stored flags and drives a take-branch output. The sequencer can therefore act on the flags left by the previous operation.

Top module: `aluf_unit`

## Requirements
- R1: ADD (op 0) gives a+b and ADC (op 1) gives a+b+cin, each truncated to W bits; carry flag C (flags_o[3]) is the carry out of the top bit.
- R2: SUB (op 2) gives a-b by adding the two's complement of b. SBB (op 3) gives a-b-(1-cin). For both, C=1 means no borrow, that is a >= b (+borrow) taken as unsigned.
- R3: Overflow V (flags_o[0]) after an arithmetic operation is set exactly when the signed result does not fit in W bits, which equals carry-into-top-bit XOR carry-out.
- R4: Z (flags_o[2]) is set when every result bit is zero. S (flags_o[1]) equals the top result bit.
- R5: NEG (op 4) gives 0-a with C=1 only for a=0. INC (op 5) gives a+1 with C=1 only for a all ones. DEC (op 6) gives a-1 with C=1 unless a=0.
- R6: AND (7), OR (8), XOR (9) and NOT (10, complement of a) give the bitwise result and clear both C and V.
- R7: CMP (op 11) sets flags as SUB does, and TST (op 12) sets flags as AND does. Neither raises wr_en_o.
- R8: CLRC (13), SETC (14) and CMC (15) clear, set or invert C, keep Z, S and V, and do not raise wr_en_o.
- R9: When flag_we_i is low, flags_o keeps its value on the clock edge, while result_o and wr_en_o still follow the inputs.
- R10: A synchronous active-high reset clears all four flags.
- R11: take_o is driven from the stored flags and cond_i as follows: 0 Z=1, 1 Z=0, 2 C=1, 3 C=0, 4 S=0, 5 S=1, 6 V=1, 7 V=0.
- R12: wr_en_o is high for ops 0 through 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code |
| a_i | input | W | First operand |
| b_i | input | W | Second operand |
| cin_i | input | 1 | Carry in for ADC; not-borrow for SBB |
| flag_we_i | input | 1 | Capture new flags on this edge |
| cond_i | input | 3 | Branch condition selector |
| result_o | output | W | Combinational result |
| wr_en_o | output | 1 | Result should be written |
| flags_o | output | 4 | Stored flags {C,Z,S,V} |
| take_o | output | 1 | Selected condition holds on stored flags |

## Verification
The assertions run on every cycle. They check that flags hold while the update enable is low, that flags are clear after reset, and that compare leaves Z equal to operand equality. They also check that SETC sets carry, that ADD overflow follows the sign rule, that Z follows a written zero result, and that the zero and minus branch tests follow the stored flags. The full opcode set needs the bench's scenarios. So do the borrow sense of subtract and subtract-with-borrow, the carry edges of negate, increment and decrement, and the claim that carry-only operations keep Z, S and V. The bench checks these against a model built on signed and unsigned integer range tests rather than on carry chains.

// File: rtl/aluf_pkg.sv
`timescale 1ns/1ps
package aluf_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'h0, OP_ADC = 4'h1, OP_SUB = 4'h2, OP_SBB = 4'h3,
    OP_NEG = 4'h4, OP_INC = 4'h5, OP_DEC = 4'h6, OP_AND = 4'h7,
    OP_OR  = 4'h8, OP_XOR = 4'h9, OP_NOT = 4'hA, OP_CMP = 4'hB,
    OP_TST = 4'hC, OP_CLC = 4'hD, OP_STC = 4'hE, OP_CMC = 4'hF
  } aluf_op_e;

  typedef enum logic [2:0] {
    CC_ZERO, CC_NZERO, CC_CARRY, CC_NCARRY,
    CC_PLUS, CC_MINUS, CC_OVF, CC_NOVF
  } aluf_cond_e;

  typedef struct packed {
    logic c;
    logic z;
    logic s;
    logic v;
  } aluf_flags_t;

  localparam int FLAG_BITS = 4;
endpackage

// File: rtl/aluf_adder.sv
`timescale 1ns/1ps
module aluf_adder #(
  parameter int W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         ci,
  output logic [W-1:0] sum,
  output logic         c_into_top,
  output logic         c_out
);
  localparam int LOW = W - 1;

  logic [W-1:0] low_sum;
  logic [1:0]   top_sum;

  // low part carries its own carry-out in the extra bit
  assign low_sum    = {1'b0, x[LOW-1:0]} + {1'b0, y[LOW-1:0]} + {{LOW{1'b0}}, ci};
  assign c_into_top = low_sum[LOW];
  assign top_sum    = {1'b0, x[LOW]} + {1'b0, y[LOW]} + {1'b0, c_into_top};
  assign sum        = {top_sum[0], low_sum[LOW-1:0]};
  assign c_out      = top_sum[1];
endmodule

// File: rtl/aluf_core.sv
`timescale 1ns/1ps
module aluf_core
  import aluf_pkg::*;
#(
  parameter int W = 16
) (
  input  aluf_op_e     op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  aluf_flags_t  flags_q,
  output logic [W-1:0] result,
  output logic         wr_en,
  output aluf_flags_t  flags_d
);
  logic [W-1:0] add_x, add_y, add_sum;
  logic         add_ci, add_cmsb, add_cout;
  logic         is_arith, is_logic;
  logic [W-1:0] logic_val;

  aluf_adder #(.W(W)) u_adder (
    .x(add_x), .y(add_y), .ci(add_ci),
    .sum(add_sum), .c_into_top(add_cmsb), .c_out(add_cout)
  );

  // operand steering: every subtraction is an addition of an inverted operand
  always_comb begin
    add_x  = a;
    add_y  = b;
    add_ci = 1'b0;
    is_arith = 1'b1;
    unique case (op)
      OP_ADD:         begin add_y = b;       add_ci = 1'b0; end
      OP_ADC:         begin add_y = b;       add_ci = cin;  end
      OP_SUB, OP_CMP: begin add_y = ~b;      add_ci = 1'b1; end
      OP_SBB:         begin add_y = ~b;      add_ci = cin;  end
      OP_NEG:         begin add_x = '0; add_y = ~a; add_ci = 1'b1; end
      OP_INC:         begin add_y = '0;      add_ci = 1'b1; end
      OP_DEC:         begin add_y = '1;      add_ci = 1'b0; end
      default:        is_arith = 1'b0;
    endcase
  end

  always_comb begin
    is_logic  = 1'b1;
    logic_val = '0;
    unique case (op)
      OP_AND, OP_TST: logic_val = a & b;
      OP_OR:          logic_val = a | b;
      OP_XOR:         logic_val = a ^ b;
      OP_NOT:         logic_val = ~a;
      default:        is_logic = 1'b0;
    endcase
  end

  always_comb begin
    result  = '0;
    flags_d = flags_q;
    if (is_arith) begin
      result    = add_sum;
      flags_d.c = add_cout;
      flags_d.v = add_cmsb ^ add_cout;
      flags_d.z = (add_sum == '0);
      flags_d.s = add_sum[W-1];
    end else if (is_logic) begin
      result    = logic_val;
      flags_d.c = 1'b0;
      flags_d.v = 1'b0;
      flags_d.z = (logic_val == '0);
      flags_d.s = logic_val[W-1];
    end else begin
      unique case (op)
        OP_CLC:  flags_d.c = 1'b0;
        OP_STC:  flags_d.c = 1'b1;
        OP_CMC:  flags_d.c = ~flags_q.c;
        default: flags_d.c = flags_q.c;
      endcase
    end
  end

  assign wr_en = !(op inside {OP_CMP, OP_TST, OP_CLC, OP_STC, OP_CMC});
endmodule

// File: rtl/aluf_flag_reg.sv
`timescale 1ns/1ps
module aluf_flag_reg
  import aluf_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        we,
  input  aluf_flags_t d,
  output aluf_flags_t q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= d;
  end
endmodule

// File: rtl/aluf_cond.sv
`timescale 1ns/1ps
module aluf_cond
  import aluf_pkg::*;
(
  input  aluf_flags_t flags,
  input  aluf_cond_e  cond,
  output logic        take
);
  logic picked;

  // pairs share a flag; the low selector bit flips the sense,
  // except the sign pair whose first entry tests S=0
  always_comb begin
    unique case (cond[2:1])
      2'd0:    picked = flags.z;
      2'd1:    picked = flags.c;
      2'd2:    picked = ~flags.s;
      default: picked = flags.v;
    endcase
    take = picked ^ cond[0];
  end
endmodule

// File: rtl/aluf_unit.sv
`timescale 1ns/1ps
module aluf_unit
  import aluf_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [3:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic         flag_we_i,
  input  logic [2:0]   cond_i,
  output logic [W-1:0] result_o,
  output logic         wr_en_o,
  output logic [3:0]   flags_o,
  output logic         take_o
);
  aluf_flags_t flags_q, flags_d;

  aluf_core #(.W(W)) u_core (
    .op(aluf_op_e'(op_i)), .a(a_i), .b(b_i), .cin(cin_i),
    .flags_q(flags_q), .result(result_o), .wr_en(wr_en_o), .flags_d(flags_d)
  );

  aluf_flag_reg u_flags (
    .clk(clk), .rst(rst), .we(flag_we_i), .d(flags_d), .q(flags_q)
  );

  aluf_cond u_cond (
    .flags(flags_q), .cond(aluf_cond_e'(cond_i)), .take(take_o)
  );

  assign flags_o = flags_q;
endmodule

// File: rtl/aluf_unit_chk.sv
`timescale 1ns/1ps
module aluf_unit_chk
  import aluf_pkg::*;
#(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic [3:0]   op_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic         flag_we_i,
  input logic [2:0]   cond_i,
  input logic [W-1:0] result_o,
  input logic         wr_en_o,
  input logic [3:0]   flags_o,
  input logic         take_o
);
  // R9
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !flag_we_i |=> $stable(flags_o));

  // R10
  rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> flags_o == 4'b0000);

  // R7
  cmp_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_we_i && op_i == OP_CMP) |=> flags_o[2] == ($past(a_i) == $past(b_i)));

  // R8
  set_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_we_i && op_i == OP_STC) |=> flags_o[3]);

  // R3
  add_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_we_i && op_i == OP_ADD) |=>
      flags_o[0] == (($past(a_i[W-1]) == $past(b_i[W-1])) &&
                     ($past(result_o[W-1]) != $past(a_i[W-1]))));

  // R4
  zero_result_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_we_i && wr_en_o) |=> flags_o[2] == ($past(result_o) == '0));

  // R11
  take_zero_chk: assert property (@(posedge clk) disable iff (rst)
    cond_i == CC_ZERO |-> take_o == flags_o[2]);

  // R11
  take_minus_chk: assert property (@(posedge clk) disable iff (rst)
    cond_i == CC_MINUS |-> take_o == flags_o[1]);
endmodule

bind aluf_unit aluf_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .op_i(op_i), .a_i(a_i), .b_i(b_i),
  .flag_we_i(flag_we_i), .cond_i(cond_i), .result_o(result_o),
  .wr_en_o(wr_en_o), .flags_o(flags_o), .take_o(take_o)
);

// File: tb/aluf_unit_bench.sv
`timescale 1ns/1ps
module aluf_unit_bench;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [3:0]   op_i = '0;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic         cin_i = 1'b0, flag_we_i = 1'b0;
  logic [2:0]   cond_i = '0;
  logic [W-1:0] result_o;
  logic         wr_en_o;
  logic [3:0]   flags_o;
  logic         take_o;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  logic [3:0] mflags = '0;

  typedef struct {
    string      tag;
    logic [W-1:0] res;
    logic       wr;
    logic [3:0] fl;
    logic       tk;
  } item_t;
  item_t sb[$];

  always #10 clk = ~clk;

  aluf_unit #(.W(W)) u_aluf_unit (
    .clk(clk), .rst(rst), .op_i(op_i), .a_i(a_i), .b_i(b_i), .cin_i(cin_i),
    .flag_we_i(flag_we_i), .cond_i(cond_i), .result_o(result_o),
    .wr_en_o(wr_en_o), .flags_o(flags_o), .take_o(take_o)
  );

  function automatic logic cond_eval(logic [3:0] f, logic [2:0] c);
    case (c)
      3'd0: return f[2];
      3'd1: return !f[2];
      3'd2: return f[3];
      3'd3: return !f[3];
      3'd4: return !f[1];
      3'd5: return f[1];
      3'd6: return f[0];
      default: return !f[0];
    endcase
  endfunction

  task automatic drive(string tag, logic [3:0] op, logic [W-1:0] a, logic [W-1:0] b,
                       logic cin, logic we, logic [2:0] cond);
    int sa, sb_, s;
    int ua, ub;
    logic c, v, wr;
    logic [W-1:0] r;
    logic [3:0] nf;
    item_t it;
    @(negedge clk);
    op_i = op; a_i = a; b_i = b; cin_i = cin; flag_we_i = we; cond_i = cond;
    sa = $signed(a); sb_ = $signed(b); ua = int'(a); ub = int'(b);
    s = 0; c = 1'b0; v = 1'b0; wr = 1'b1; r = '0; nf = mflags;
    if (op <= 4'd6 || op == 4'd11) begin
      case (op)
        4'd0: begin s = sa + sb_;          c = (ua + ub) > 65535; end
        4'd1: begin s = sa + sb_ + cin;    c = (ua + ub + cin) > 65535; end
        4'd3: begin s = sa - sb_ - (1 - cin); c = ua >= ub + (1 - cin); end
        4'd4: begin s = -sa;               c = (ua == 0); end
        4'd5: begin s = sa + 1;            c = (ua == 65535); end
        4'd6: begin s = sa - 1;            c = (ua != 0); end
        default: begin s = sa - sb_;       c = ua >= ub; end
      endcase
      v = (s > 32767) || (s < -32768);
      r = s[W-1:0];
      nf = {c, r == '0, r[W-1], v};
    end else if (op <= 4'd12) begin
      case (op)
        4'd8: r = a | b;
        4'd9: r = a ^ b;
        4'd10: r = ~a;
        default: r = a & b;
      endcase
      nf = {1'b0, r == '0, r[W-1], 1'b0};
    end else begin
      nf[3] = (op == 4'd13) ? 1'b0 : (op == 4'd14) ? 1'b1 : !mflags[3];
    end
    wr = (op <= 4'd10);
    if (we) mflags = nf;
    it.tag = tag; it.res = r; it.wr = wr; it.fl = mflags; it.tk = cond_eval(mflags, cond);
    sb.push_back(it);
  endtask

  // monitor: compares after the edge that follows each drive
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        it = sb.pop_front();
        tests++;
        if ((it.wr && result_o !== it.res) || wr_en_o !== it.wr ||
            flags_o !== it.fl || take_o !== it.tk) begin
          fails++;
          $display("FAIL %s: res=%h/%h wr=%b/%b flags=%b/%b take=%b/%b", it.tag,
                   result_o, it.res, wr_en_o, it.wr, flags_o, it.fl, take_o, it.tk);
        end
      end
    end
  end

  task automatic direct(string tag, bit ok, logic [3:0] act, logic [3:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    direct("R10 reset flags", flags_o === 4'b0000, flags_o, 4'b0000);
    rst = 1'b0;
    drive("R1 add plain",      4'd0, 16'h1234, 16'h0001, 0, 1, 3'd1);
    drive("R1 add wrap",       4'd0, 16'hFFFF, 16'h0001, 0, 1, 3'd0); // R4 zero
    drive("R3 add pos ovf",    4'd0, 16'h7FFF, 16'h0001, 0, 1, 3'd6);
    drive("R3 add neg ovf",    4'd0, 16'h8000, 16'h8000, 0, 1, 3'd2);
    drive("R1 adc",            4'd1, 16'h00FF, 16'h0001, 1, 1, 3'd4);
    drive("R2 sub no borrow",  4'd2, 16'd5, 16'd3, 0, 1, 3'd2);
    drive("R2 sub borrow",     4'd2, 16'd3, 16'd5, 0, 1, 3'd5); // R4 sign
    drive("R3 sub ovf",        4'd2, 16'h8000, 16'h0001, 0, 1, 3'd7);
    drive("R2 sbb borrow in",  4'd3, 16'd10, 16'd3, 0, 1, 3'd3);
    drive("R2 sbb no borrow",  4'd3, 16'd3, 16'd3, 1, 1, 3'd0);
    drive("R5 neg",            4'd4, 16'd5, 16'd0, 0, 1, 3'd5);
    drive("R5 neg zero",       4'd4, 16'd0, 16'd0, 0, 1, 3'd2);
    drive("R5 inc wrap",       4'd5, 16'hFFFF, 16'd0, 0, 1, 3'd0);
    drive("R5 dec zero",       4'd6, 16'd0, 16'd0, 0, 1, 3'd3);
    drive("R6 and",            4'd7, 16'hF0F0, 16'hFF00, 0, 1, 3'd5);
    drive("R6 or",             4'd8, 16'h0F00, 16'h00F0, 0, 1, 3'd1);
    drive("R6 xor",            4'd9, 16'hAAAA, 16'hAAAA, 0, 1, 3'd0);
    drive("R6 not",            4'd10, 16'h00FF, 16'h0000, 0, 1, 3'd5);
    drive("R7 cmp equal",      4'd11, 16'h4321, 16'h4321, 0, 1, 3'd0);
    drive("R7 cmp less",       4'd11, 16'h0001, 16'h0002, 0, 1, 3'd3);
    drive("R7 tst",            4'd12, 16'h8001, 16'h8000, 0, 1, 3'd5);
    drive("R8 setc",           4'd14, 16'h0, 16'h0, 0, 1, 3'd2);
    drive("R8 cmc",            4'd15, 16'h0, 16'h0, 0, 1, 3'd3);
    drive("R8 cmc again",      4'd15, 16'h0, 16'h0, 0, 1, 3'd2);
    drive("R8 clrc",           4'd13, 16'h0, 16'h0, 0, 1, 3'd5);
    drive("R3 setup ovf",      4'd0, 16'h7FFF, 16'h7FFF, 0, 1, 3'd6);
    drive("R9 hold add",       4'd0, 16'h0001, 16'hFFFF, 0, 0, 3'd6);
    drive("R9 hold sub",       4'd2, 16'd9, 16'd2, 0, 0, 3'd1);
    for (int c = 0; c < 8; c++)
      drive("R11 cond sweep",  4'd12, 16'h0, 16'h0, 0, 0, 3'(c));
    drive("R12 not writes",    4'd10, 16'h1234, 16'h0, 0, 0, 3'd0);
    @(negedge clk);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #2;
    direct("R10 mid-run reset", flags_o === 4'b0000, flags_o, 4'b0000);
    mflags = '0;
    @(negedge clk);
    rst = 1'b0;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(64'd20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule